// File: doc/BRIEF.md
# Three-Level Symmetric Space-Vector Gate Sequencer

This block drives the twelve gate signals of a three-phase, three-level neutral-point-clamped inverter bridge for one modulation period at a time. A controller upstream works out two active-vector dwell times and a zero-vector time, all in clock ticks, and picks the per-phase three-level state of each active vector and of three zero vectors. The sequencer plays these states back as a pattern that is mirror-symmetric about the centre of the period. It then turns each phase state into the four switch commands of that leg.

The period runs in seven segments: a leading zero, the first half of active A, the first half of active B, the centre zero, the second half of B, the second half of A, and a trailing zero. Segment inputs are sampled only when a period starts, so a pattern never changes part-way through. Segments with no ticks are passed over. A one-cycle flag marks the final tick of every period, so the controller knows when to present the next set of values. With a 50 MHz clock, a 0.4 ms period corresponds to 20000 ticks.

Top module: `svpwm3_gate_seq`

## Requirements
- R1: While reset is asserted, and until the first period starts, every phase is held at the midpoint state (both inner switches on, both outer switches off) and period_done is low.
- R2: Each phase takes a 2-bit code from bits [2p+1:2p] (phase a p=0, b p=1, c p=2): 01 = +1 turns on the upper outer and upper inner switches, 00 = 0 turns on both inner switches, 11 = -1 turns on the lower inner and lower outer switches, and the unused code 10 is treated as 0.
- R3: In every cycle, upper outer and lower inner are complementary in each phase, and so are upper inner and lower outer.
- R4: Segments appear in the order leading zero, A, B, centre zero, B, A, trailing zero. Their states are taken from the leading-zero code, code_a, code_b, the centre-zero code, code_b, code_a and the trailing-zero code.
- R5: Each A segment lasts floor(dwell_a/2) ticks and each B segment floor(dwell_b/2) ticks. Each end zero lasts floor(dwell_z/3) ticks. The centre zero takes the rest of the zero time plus the odd tick of each active time, so a period lasts exactly dwell_a+dwell_b+dwell_z ticks. An all-zero input gives a single centre tick.
- R6: A segment with zero ticks never shows its state for any cycle.
- R7: Dwell times and state codes are sampled only at the clock edge that starts a period. Changes to them during a period do not affect that period.
- R8: period_done is high exactly during the last tick of every period and low otherwise.
- R9: The first period starts at the first rising clock edge after reset is released, and each later period starts at the edge right after the previous period's last tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dwell_a | input | TW | Active vector A dwell time in ticks |
| dwell_b | input | TW | Active vector B dwell time in ticks |
| dwell_z | input | TW | Total zero-vector time in ticks |
| code_a | input | 6 | Phase codes of active vector A |
| code_b | input | 6 | Phase codes of active vector B |
| code_z_first | input | 6 | Phase codes of the leading zero vector |
| code_z_mid | input | 6 | Phase codes of the centre zero vector |
| code_z_last | input | 6 | Phase codes of the trailing zero vector |
| up_out | output | 3 | Upper outer switch per phase (bit 0 = a) |
| up_in | output | 3 | Upper inner switch per phase |
| dn_in | output | 3 | Lower inner switch per phase |
| dn_out | output | 3 | Lower outer switch per phase |
| period_done | output | 1 | High during the last tick of a period |

## Verification
The assertions assume only that the inputs are defined at each period-start edge. The block forces a non-empty period itself, so no input value can stall it. The bench holds the inputs steady across every start edge. It then writes a different set of values on the first tick of each period, so the latching property is tested every period. The sweep covers all active times from 0 to 3 and zero times from 0 to 5, including the all-zero case. The state codes rotate through every 2-bit value, including the unused one.

// File: rtl/svpwm3_gate_seq.sv
module svpwm3_gate_seq #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] dwell_a,
  input  logic [TW-1:0] dwell_b,
  input  logic [TW-1:0] dwell_z,
  input  logic [5:0]    code_a,
  input  logic [5:0]    code_b,
  input  logic [5:0]    code_z_first,
  input  logic [5:0]    code_z_mid,
  input  logic [5:0]    code_z_last,
  output logic [2:0]    up_out,
  output logic [2:0]    up_in,
  output logic [2:0]    dn_in,
  output logic [2:0]    dn_out,
  output logic          period_done
);

  localparam int CW    = TW + 1;
  localparam int NSEG  = 7;
  localparam int NPH   = 3;

  logic          run;
  logic [TW-1:0] lta, ltb, ltz;
  logic [5:0]    lca, lcb, lzf, lzm, lzl;
  logic [2:0]    seg;
  logic [CW-1:0] rem;
  logic [5:0]    cur;

  function automatic logic [CW-1:0] seg_len(input logic [2:0] k,
      input logic [TW-1:0] ta, input logic [TW-1:0] tb, input logic [TW-1:0] tz);
    logic [TW-1:0] zt;
    logic [CW-1:0] ctr;
    zt  = tz / TW'(3);
    ctr = CW'(tz) - {zt, 1'b0} + CW'(ta[0]) + CW'(tb[0]);
    if (ta == '0 && tb == '0 && tz == '0) ctr = CW'(1);
    case (k)
      3'd0, 3'd6: seg_len = CW'(zt);
      3'd1, 3'd5: seg_len = CW'(ta >> 1);
      3'd2, 3'd4: seg_len = CW'(tb >> 1);
      default:    seg_len = ctr;
    endcase
  endfunction

  function automatic logic [3:0] first_nz(input logic [3:0] from,
      input logic [TW-1:0] ta, input logic [TW-1:0] tb, input logic [TW-1:0] tz);
    first_nz = 4'(NSEG);
    for (int k = NSEG - 1; k >= 0; k--)
      if (4'(k) >= from && seg_len(3'(k), ta, tb, tz) != '0) first_nz = 4'(k);
  endfunction

  function automatic logic [5:0] code_of(input logic [2:0] k, input logic [5:0] ca,
      input logic [5:0] cb, input logic [5:0] zf, input logic [5:0] zm, input logic [5:0] zl);
    case (k)
      3'd0:       code_of = zf;
      3'd1, 3'd5: code_of = ca;
      3'd2, 3'd4: code_of = cb;
      3'd3:       code_of = zm;
      default:    code_of = zl;
    endcase
  endfunction

  logic [3:0] nxt, start_s;
  logic       load;

  assign nxt         = first_nz({1'b0, seg} + 4'd1, lta, ltb, ltz);
  assign start_s     = first_nz(4'd0, dwell_a, dwell_b, dwell_z);
  assign period_done = run && rem == CW'(1) && nxt == 4'(NSEG);
  assign load        = !run || period_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= 1'b0;
      lta <= '0; ltb <= '0; ltz <= '0;
      lca <= '0; lcb <= '0; lzf <= '0; lzm <= '0; lzl <= '0;
      seg <= '0;
      rem <= '0;
      cur <= '0;
    end else if (load) begin
      run <= 1'b1;
      lta <= dwell_a; ltb <= dwell_b; ltz <= dwell_z;
      lca <= code_a; lcb <= code_b;
      lzf <= code_z_first; lzm <= code_z_mid; lzl <= code_z_last;
      seg <= start_s[2:0];
      rem <= seg_len(start_s[2:0], dwell_a, dwell_b, dwell_z);
      cur <= code_of(start_s[2:0], code_a, code_b, code_z_first, code_z_mid, code_z_last);
    end else if (rem == CW'(1)) begin
      seg <= nxt[2:0];
      rem <= seg_len(nxt[2:0], lta, ltb, ltz);
      cur <= code_of(nxt[2:0], lca, lcb, lzf, lzm, lzl);
    end else begin
      rem <= rem - CW'(1);
    end
  end

  for (genvar p = 0; p < NPH; p++) begin : g_leg
    logic [1:0] ph;
    assign ph        = cur[2*p +: 2];
    assign up_out[p] = ph == 2'b01;
    assign dn_out[p] = ph == 2'b11;
    assign up_in[p]  = !dn_out[p];
    assign dn_in[p]  = !up_out[p];
  end

  a_r1_idle_mid: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (cur == 6'd0 && !period_done));

  a_r3_pairs: assert property (@(posedge clk) disable iff (!rst_n)
    ((up_out ^ dn_in) == 3'b111) && ((up_in ^ dn_out) == 3'b111));

  a_r4_forward: assert property (@(posedge clk) disable iff (!rst_n)
    (run && rem == CW'(1) && !period_done) |=> seg > $past(seg));

  a_r5_live_seg: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> rem != '0);

  a_r6_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (run && rem > CW'(1)) |=> $stable(cur));

  a_r7_sample: assert property (@(posedge clk) disable iff (!rst_n)
    period_done |=> (lta == $past(dwell_a) && ltb == $past(dwell_b) &&
                     ltz == $past(dwell_z) && lca == $past(code_a)));

  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !period_done) |=> ($stable(lta) && $stable(ltb) && $stable(ltz) &&
                               $stable(lca) && $stable(lcb) && $stable(lzm)));

endmodule

// File: tb/test_svpwm3_gate_seq.sv
module test_svpwm3_gate_seq;
  localparam int TW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [TW-1:0] dwell_a = '0, dwell_b = '0, dwell_z = '0;
  logic [5:0]    code_a = '0, code_b = '0, code_z_first = '0, code_z_mid = '0, code_z_last = '0;
  logic [2:0]    up_out, up_in, dn_in, dn_out;
  logic          period_done;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  svpwm3_gate_seq #(.TW(TW)) i_svpwm3_gate_seq (
    .clk(clk), .rst_n(rst_n),
    .dwell_a(dwell_a), .dwell_b(dwell_b), .dwell_z(dwell_z),
    .code_a(code_a), .code_b(code_b),
    .code_z_first(code_z_first), .code_z_mid(code_z_mid), .code_z_last(code_z_last),
    .up_out(up_out), .up_in(up_in), .dn_in(dn_in), .dn_out(dn_out),
    .period_done(period_done)
  );

  always #10 clk = ~clk;

  function automatic logic [11:0] gates_of(input logic [5:0] c);
    logic [2:0] uo, ui, di, dl;
    for (int p = 0; p < 3; p++) begin
      logic [1:0] s;
      s = c[2*p +: 2];
      uo[p] = (s == 2'b01);
      dl[p] = (s == 2'b11);
      ui[p] = (s != 2'b11);
      di[p] = (s != 2'b01);
    end
    return {uo, ui, di, dl};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic do_period(input int ta, input int tb, input int tz,
      input logic [5:0] ca, input logic [5:0] cb, input logic [5:0] zf,
      input logic [5:0] zm, input logic [5:0] zl, input bit first);
    int ln[7];
    logic [5:0] cd[7];
    int total;
    ln[0] = tz / 3; ln[6] = tz / 3;
    ln[1] = ta / 2; ln[5] = ta / 2;
    ln[2] = tb / 2; ln[4] = tb / 2;
    ln[3] = tz - 2 * (tz / 3) + (ta % 2) + (tb % 2);
    if (ta == 0 && tb == 0 && tz == 0) ln[3] = 1;
    cd[0] = zf; cd[1] = ca; cd[2] = cb; cd[3] = zm; cd[4] = cb; cd[5] = ca; cd[6] = zl;
    total = 0;
    for (int k = 0; k < 7; k++) total += ln[k];
    check("R5 period length", 32'(total), 32'(ta + tb + tz + ((ta + tb + tz) == 0 ? 1 : 0)));
    for (int i = 0; i < total; i++) begin
      int acc;
      logic [5:0] ec;
      @(negedge clk);
      acc = 0;
      ec = 6'd0;
      for (int k = 0; k < 7; k++) begin
        if (i >= acc && i < acc + ln[k]) ec = cd[k];
        acc += ln[k];
      end
      if (first && i == 0)
        check("R9 first tick R2 R4", {20'd0, up_out, up_in, dn_in, dn_out}, {20'd0, gates_of(ec)});
      else
        check("R2 R4 R5 R6 R7 gates", {20'd0, up_out, up_in, dn_in, dn_out}, {20'd0, gates_of(ec)});
      check("R3 complement", {26'd0, up_out ^ dn_in, up_in ^ dn_out}, {26'd0, 6'b111111});
      check("R8 done", {31'd0, period_done}, {31'd0, (i == total - 1)});
      if (i == 0) begin
        dwell_a = 8'd77; dwell_b = 8'd91; dwell_z = 8'd45;
        code_a = ~ca; code_b = ~cb; code_z_first = 6'h3F;
        code_z_mid = ~zm; code_z_last = 6'h15;
      end
    end
  endtask

  initial begin
    int n;
    logic [5:0] ca, cb, zf, zm, zl;
    @(negedge clk);
    check("R1 reset gates", {20'd0, up_out, up_in, dn_in, dn_out}, {20'd0, gates_of(6'd0)});
    check("R1 reset done", {31'd0, period_done}, 32'd0);
    @(negedge clk);
    n = 0;
    ca = 6'h01; cb = 6'h0D; zf = 6'h00; zm = 6'h2A; zl = 6'h3F;
    dwell_a = 8'd3; dwell_b = 8'd2; dwell_z = 8'd5;
    code_a = ca; code_b = cb; code_z_first = zf; code_z_mid = zm; code_z_last = zl;
    rst_n = 1'b1;
    do_period(3, 2, 5, ca, cb, zf, zm, zl, 1'b1);
    for (int tz = 0; tz < 6; tz++)
      for (int ta = 0; ta < 4; ta++)
        for (int tb = 0; tb < 4; tb++) begin
          n++;
          ca = 6'(n * 7 + 1); cb = 6'(n * 13 + 5); zf = 6'(n * 5);
          zm = 6'(n * 3 + 2); zl = 6'(n * 11 + 9);
          dwell_a = 8'(ta); dwell_b = 8'(tb); dwell_z = 8'(tz);
          code_a = ca; code_b = cb; code_z_first = zf; code_z_mid = zm; code_z_last = zl;
          do_period(ta, tb, tz, ca, cb, zf, zm, zl, 1'b0);
        end
    dwell_a = 8'd20; dwell_b = 8'd20; dwell_z = 8'd20;
    code_a = 6'h15; code_b = 6'h3F; code_z_first = 6'h15; code_z_mid = 6'h15; code_z_last = 6'h15;
    repeat (5) @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1 reset mid-period gates", {20'd0, up_out, up_in, dn_in, dn_out}, {20'd0, gates_of(6'd0)});
    check("R1 reset mid-period done", {31'd0, period_done}, 32'd0);
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog R9 actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule